// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Event Capture and Notification Routing

This block is an eight-pin general-purpose I/O port. Software drives output levels and output enables, and it reads back the pin levels after they have been synchronised to the core clock. Through a small register interface it also configures each pin to detect events. A pin event is either a level or a change of level. The configured polarity selects high level or rising edge, or low level or falling edge.

A detected event is held in a per-pin status bit until software clears it by writing a one to that bit. A per-pin enable bit gates the status bit into system notification. Each enabled, pending event goes to an interrupt-request output, to a system-management-interrupt output, or to both, as the pin's routing settings select. A port-wide pending flag shows when any enabled status bit is set. All register reads are combinational from the address. Writes take effect on the clock edge.

Address map (5-bit address): 0 = output data, 1 = input data (read only), 2 = event enable, 3 = event status (write 1 to clear). For pin n, address 16+2n holds the pin configuration and address 17+2n holds the pin routing. Every other address reads 0, and writes to it are ignored.

Top module: `gpio_event_port`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, and right after it, every register reads 0 and `pinOe`, `pinOut`, `irq`, `smi` and `pending` are 0.
- R2: A write to address 0 sets `pinOut` to the written byte at the next edge. `pinOe[n]` equals bit 0 (output enable) of pin n's configuration register.
- R3: A read of address 1 returns `pinIn` as sampled two clock edges earlier, through a two-flop synchroniser.
- R4: With configuration bit 1 = 0 (level mode), the status bit of pin n is set at each edge where the synchronised level equals configuration bit 2 (1 = high, 0 = low).
- R5: With configuration bit 1 = 1 (edge mode), the status bit of pin n is set at the edge after the synchronised level changes to the polarity level (bit 2: 1 = rising, 0 = falling). A steady level sets nothing more.
- R6: A write to address 3 clears the status bits written as 1 and leaves the bits written as 0 unchanged. A new event in the same cycle wins over the clear, so a level-mode pin whose level is still active sets its bit again.
- R7: `pending` is combinationally the OR over all pins of (status AND enable). Address 2 holds the enable bits.
- R8: `irq` is registered and, one edge later, equals the OR of status AND enable AND routing bit 0 over all pins. `smi` does the same with routing bit 1.
- R9: Configuration registers read back bits [2:0] and routing registers read back bits [1:0], with all other bits reading 0. Writes to address 1 or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output levels driven to the pads |
| pinOe | output | 8 | Per-pin output enable |
| irq | output | 1 | Interrupt request, active high, registered |
| smi | output | 1 | System-management interrupt, active high, registered |
| pending | output | 1 | Any enabled event status bit is set |

## Verification
The embedded assertions check several properties on every cycle. The synchroniser holds a two-edge delay. Any detected event appears in the status register on the next edge. `pending` can be high only while some enable bit is set. A rise of `irq` or `smi` always follows a cycle with `pending` high. An output-data write shows up on `pinOut`. The assertion on the decoder keeps write strobes mutually exclusive. The polarity and mode choices, the set-over-clear priority for a still-active level pin, the exact routing to either output, and the writes that are ignored can only be shown by the bench scenarios. The bench compares these against its reference model.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;
  localparam int NPINS  = 8;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 5;
  localparam int PIN_W  = $clog2(NPINS);
  localparam int CFG_W  = 3;
  localparam int RT_W   = 2;

  localparam int CFG_OE   = 0;
  localparam int CFG_EDGE = 1;
  localparam int CFG_POL  = 2;
  localparam int RT_IRQ   = 0;
  localparam int RT_SMI   = 1;

  localparam logic [1:0] A_DOUT = 2'd0;
  localparam logic [1:0] A_DIN  = 2'd1;
  localparam logic [1:0] A_EVEN = 2'd2;
  localparam logic [1:0] A_EVST = 2'd3;

  typedef enum logic [2:0] {
    SEL_DOUT, SEL_DIN, SEL_EVEN, SEL_EVST, SEL_CFG, SEL_ROUTE, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic             wrDout;
    logic             wrEven;
    logic             clrEvst;
    logic             wrCfg;
    logic             wrRoute;
    logic [PIN_W-1:0] pin;
    logic [REG_W-1:0] data;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
  import gpio_event_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  output ctrlStrobes_t        stb,
  output rdSel_e              rdSel,
  output logic [PIN_W-1:0]    rdPin
);
  logic cfgSpace;
  logic lowSpace;

  assign cfgSpace = addr[ADDR_W-1];
  assign lowSpace = (addr[ADDR_W-2:2] == '0) && !cfgSpace;
  assign rdPin    = addr[PIN_W:1];

  always_comb begin
    rdSel = SEL_NONE;
    if (cfgSpace)      rdSel = addr[0] ? SEL_ROUTE : SEL_CFG;
    else if (lowSpace) begin
      unique case (addr[1:0])
        A_DOUT:  rdSel = SEL_DOUT;
        A_DIN:   rdSel = SEL_DIN;
        A_EVEN:  rdSel = SEL_EVEN;
        default: rdSel = SEL_EVST;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.pin     = rdPin;
    stb.data    = wrData;
    if (wrEn) begin
      stb.wrDout  = (rdSel == SEL_DOUT);
      stb.wrEven  = (rdSel == SEL_EVEN);
      stb.clrEvst = (rdSel == SEL_EVST);
      stb.wrCfg   = (rdSel == SEL_CFG);
      stb.wrRoute = (rdSel == SEL_ROUTE);
    end
  end

  // R9: at most one register is written per cycle
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDout, stb.wrEven, stb.clrEvst, stb.wrCfg, stb.wrRoute}));
endmodule

// File: rtl/gpio_event_dp.sv
module gpio_event_dp
  import gpio_event_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     stb,
  input  rdSel_e           rdSel,
  input  logic [PIN_W-1:0] rdPin,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic [REG_W-1:0] rdData,
  output logic             irq,
  output logic             smi,
  output logic             pending
);
  logic [NPINS-1:0] doutReg, evenReg, evstReg;
  logic [NPINS-1:0] sync1, sync2, prevLvl;
  logic [NPINS-1:0] evtVec, routeIrq, routeSmi, armed;
  logic [CFG_W-1:0] cfgReg [NPINS];
  logic [RT_W-1:0]  rtReg  [NPINS];
  logic [NPINS-1:0] clrMask;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic activeLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgReg[n] <= '0;
        rtReg[n]  <= '0;
      end else begin
        if (stb.wrCfg   && stb.pin == PIN_W'(n)) cfgReg[n] <= stb.data[CFG_W-1:0];
        if (stb.wrRoute && stb.pin == PIN_W'(n)) rtReg[n]  <= stb.data[RT_W-1:0];
      end
    end
    assign activeLvl   = (sync2[n] == cfgReg[n][CFG_POL]);
    assign evtVec[n]   = cfgReg[n][CFG_EDGE] ? (activeLvl && (sync2[n] != prevLvl[n]))
                                             : activeLvl;
    assign pinOe[n]    = cfgReg[n][CFG_OE];
    assign routeIrq[n] = rtReg[n][RT_IRQ];
    assign routeSmi[n] = rtReg[n][RT_SMI];
  end

  assign clrMask = stb.clrEvst ? stb.data[NPINS-1:0] : '0;
  assign armed   = evstReg & evenReg;
  assign pending = |armed;
  assign pinOut  = doutReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutReg <= '0;
      evenReg <= '0;
      evstReg <= '0;
      sync1   <= '0;
      sync2   <= '0;
      prevLvl <= '0;
      irq     <= 1'b0;
      smi     <= 1'b0;
    end else begin
      sync1   <= pinIn;
      sync2   <= sync1;
      prevLvl <= sync2;
      evstReg <= (evstReg & ~clrMask) | evtVec;
      irq     <= |(armed & routeIrq);
      smi     <= |(armed & routeSmi);
      if (stb.wrDout) doutReg <= stb.data[NPINS-1:0];
      if (stb.wrEven) evenReg <= stb.data[NPINS-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_DOUT:  rdData = REG_W'(doutReg);
      SEL_DIN:   rdData = REG_W'(sync2);
      SEL_EVEN:  rdData = REG_W'(evenReg);
      SEL_EVST:  rdData = REG_W'(evstReg);
      SEL_CFG:   rdData = REG_W'(cfgReg[rdPin]);
      SEL_ROUTE: rdData = REG_W'(rtReg[rdPin]);
      default:   rdData = '0;
    endcase
  end

  // Cycles since reset, saturating, for the synchroniser window
  logic [1:0] cycSinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycSinceRst <= '0;
    else if (cycSinceRst != 2'd2) cycSinceRst <= cycSinceRst + 2'd1;
  end

  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cycSinceRst == 2'd2) |-> (sync2 == $past(pinIn, 2)));

  p_event_captured_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((evstReg & $past(evtVec)) == $past(evtVec)));

  p_pending_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (|evenReg));

  p_irq_after_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(pending));

  p_smi_after_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smi) |-> $past(pending));

  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDout |=> (pinOut == $past(stb.data[NPINS-1:0])));
endmodule

// File: rtl/gpio_event_port.sv
module gpio_event_port
  import gpio_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irq,
  output logic              smi,
  output logic              pending
);
  ctrlStrobes_t     stb;
  rdSel_e           rdSel;
  logic [PIN_W-1:0] rdPin;

  gpio_event_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .stb(stb), .rdSel(rdSel), .rdPin(rdPin)
  );

  gpio_event_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .rdPin(rdPin),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData),
    .irq(irq), .smi(smi), .pending(pending)
  );
endmodule

// File: tb/gpio_event_port_tb.sv
`timescale 1ns/1ps
module gpio_event_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] pinIn = '0;
  logic [7:0] rdData, pinOut, pinOe;
  logic       irq, smi, pending;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  gpio_event_port u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irq(irq), .smi(smi), .pending(pending)
  );

  // Behavioural reference model
  bit [7:0] mDout, mEven, mEvst, mS1, mS2, mPrev;
  bit [2:0] mCfg [8];
  bit [1:0] mRt  [8];
  bit       mIrq, mSmi;

  function automatic bit [7:0] expRd(input bit [4:0] a);
    if (a[4]) return a[0] ? {6'b0, mRt[a[3:1]]} : {5'b0, mCfg[a[3:1]]};
    case (a)
      5'd0: return mDout;
      5'd1: return mS2;
      5'd2: return mEven;
      5'd3: return mEvst;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDout = 0; mEven = 0; mEvst = 0; mS1 = 0; mS2 = 0; mPrev = 0;
      mIrq = 0; mSmi = 0;
      for (int i = 0; i < 8; i++) begin mCfg[i] = 0; mRt[i] = 0; end
    end else begin
      bit [7:0] ev;
      bit nIrq, nSmi;
      nIrq = 0; nSmi = 0;
      for (int i = 0; i < 8; i++) begin
        bit act;
        act = (mS2[i] == mCfg[i][2]);
        ev[i] = mCfg[i][1] ? (act && mS2[i] != mPrev[i]) : act;
        if (mEvst[i] && mEven[i] && mRt[i][0]) nIrq = 1;
        if (mEvst[i] && mEven[i] && mRt[i][1]) nSmi = 1;
      end
      mIrq = nIrq; mSmi = nSmi;
      if (wrEn && addr == 5'd3) mEvst = mEvst & ~wrData;
      mEvst = mEvst | ev;
      if (wrEn && addr == 5'd0) mDout = wrData;
      if (wrEn && addr == 5'd2) mEven = wrData;
      if (wrEn && addr[4] && !addr[0]) mCfg[addr[3:1]] = wrData[2:0];
      if (wrEn && addr[4] &&  addr[0]) mRt[addr[3:1]]  = wrData[1:0];
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic string rdTag(input bit [4:0] a);
    if (a[4]) return "R9 config readback";
    case (a)
      5'd0: return "R2 data out";
      5'd1: return "R3 data in";
      5'd2: return "R7 enable";
      5'd3: return "R4/R5/R6 status";
      default: return "R9 unmapped";
    endcase
  endfunction

  // Compare on every clock, away from the edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rstN && !done) begin
      bit [7:0] oe;
      bit pend;
      pend = |(mEvst & mEven);
      for (int i = 0; i < 8; i++) oe[i] = mCfg[i][0];
      check("R2 pinOut", pinOut, mDout);
      check("R2 pinOe", pinOe, oe);
      check(rdTag(addr), rdData, expRd(addr));
      check("R7 pending", {7'b0, pending}, {7'b0, pend});
      check("R8 irq", {7'b0, irq}, {7'b0, mIrq});
      check("R8 smi", {7'b0, smi}, {7'b0, mSmi});
    end
  end

  task automatic wr(input bit [4:0] a, input bit [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input bit [4:0] a);
    @(negedge clk); addr = a; wrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1;
    // R1: state during reset
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    check("R1 pinOe in reset", pinOe, 8'h00);
    idle(3);
    rstN = 1;
    @(posedge clk); #2;
    check("R1 rdData after reset", rdData, 8'h00);
    check("R1 pending after reset", {7'b0, pending}, 8'h00);

    // R2: outputs
    wr(5'd0, 8'hA5);
    for (int n = 0; n < 4; n++) wr(5'(16 + 2*n), 8'h01);
    rd(5'd0); idle(2);

    // R3: input sync
    pinIn = 8'h3C; rd(5'd1); idle(3);
    pinIn = 8'hC3; idle(3);
    pinIn = 8'h00; idle(3);

    // R4 level high on pin0 routed to irq
    wr(5'd16, 8'b101); wr(5'd17, 8'b01); wr(5'd2, 8'h01);
    pinIn[0] = 1; rd(5'd3); idle(5);
    wr(5'd3, 8'h01); rd(5'd3); idle(2);   // R6 re-set while active
    pinIn[0] = 0; idle(3);
    wr(5'd3, 8'h01); idle(3);

    // R5 falling edge on pin1 routed to smi
    wr(5'd18, 8'b010); wr(5'd19, 8'b10); wr(5'd2, 8'h03);
    pinIn[1] = 1; rd(5'd3); idle(4);
    pinIn[1] = 0; idle(5);
    wr(5'd3, 8'h00); idle(2);             // R6 zero write no effect
    wr(5'd3, 8'h02); idle(3);

    // R5 rising edge on pin2 routed both
    wr(5'd20, 8'b110); wr(5'd21, 8'b11); wr(5'd2, 8'h07);
    pinIn[2] = 1; rd(5'd3); idle(5);
    wr(5'd3, 8'h04); idle(3);

    // R4 level low on pin3, no routing
    wr(5'd22, 8'b000); wr(5'd2, 8'h08); rd(5'd3); idle(4);
    wr(5'd3, 8'hFF); idle(3);
    pinIn[3] = 1; idle(3); wr(5'd3, 8'h08); idle(3);

    // R9 ignored writes and readback masking
    wr(5'd1, 8'hFF); rd(5'd1); idle(2);
    wr(5'd5, 8'hFF); rd(5'd5); idle(2);
    wr(5'd24, 8'hFF); rd(5'd24); idle(2);
    wr(5'd25, 8'hFF); rd(5'd25); idle(2);
    rd(5'd0); idle(1); rd(5'd2); idle(1);

    // Random mix of all features
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      pinIn  = 8'($urandom);
      addr   = 5'($urandom);
      wrData = 8'($urandom);
      wrEn   = ($urandom % 3) == 0;
    end
    @(negedge clk); wrEn = 0;
    idle(4);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule